// File: doc/BRIEF.md
# Secondary Bus Reset Sequencer

This block runs the reset of a switch's downstream side after software sets a reset-control bit. When the bit rises, the block records which ports the reset covers. It then steps through a fixed sequence:
- It asks the link layer to send training sets with the hot-reset flag. Only ports whose link is up at the start are asked.
- It strobes a discard of the TLPs that are still queued from those ports.
- In the upstream-initiated scope, it pulses a clear of every downstream port's non-sticky register fields.
- It holds in a wait state until software clears the bit. It then passes through a short resume state and returns to idle.

While the sequence runs, every TLP is classified as it passes. A TLP that is routed to the secondary side of an affected bridge gets an unsupported-request verdict. A Type 0 configuration access aimed at the port itself still completes normally.

A mode input picks the scope. In the upstream-initiated scope, the reset covers all downstream ports. In the downstream-initiated scope, it covers the single port named by a select input, and the other ports see no activity. Link training, ordered-set generation and the register file sit outside this block.

Top module: `sbr_reset_seq`

## Requirements
- R1: After reset, `busy` and every other output are low. `busy` goes high in the cycle after the clock edge that samples a rising edge of `sbr_ctl` while idle. `busy` stays high until the sequence returns to idle.
- R2: For HOT_CYCLES cycles starting with the first busy cycle, bit i of `hot_reset_req` is high only if two conditions hold. Port i must be in scope, and `link_up[i]` must have been high on the starting edge.
- R3: If `link_up[i]` is sampled low at an edge while `hot_reset_req[i]` is asserted, `hot_reset_req[i]` is low from the next cycle on and does not return during that sequence. The sequence itself keeps running.
- R4: In the cycle after the hot-reset phase, `flush_strobe` is high for exactly one cycle. It is high on the bits of the in-scope ports only, whatever their link state.
- R5: When `up_scope` = 1 was captured, `reg_reset_pulse` is all ones for exactly one cycle, in the cycle after the flush strobe.
- R6: When `up_scope` = 0 was captured, `reg_reset_pulse` stays zero. Only bit `port_sel` of `hot_reset_req` and `flush_strobe` can be set, where bit i stands for downstream port i.
- R7: The block holds busy while `sbr_ctl` is high after the register-reset step. The first edge in that wait state that samples `sbr_ctl` low moves it to resume, and `busy` drops one cycle later. A bit that was cleared early still costs one wait cycle.
- R8: `up_scope` and `port_sel` are captured on the starting edge. Changes to them while busy have no effect on any output until the block is idle again.
- R9: `ur_valid` repeats `tlp_valid` one cycle later. `ur_flag` is set only if all of the following held on that edge:
  - `tlp_valid` was high and the block was busy;
  - `tlp_to_sec` was high and `tlp_cfg_self` was low;
  - in the downstream scope, `tlp_port` equalled the captured port. In the upstream scope, any port qualifies.
- R10: A TLP with `tlp_cfg_self` high, a TLP for a port outside the scope, and any TLP while idle all get `ur_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbr_ctl | input | 1 | Software reset-control bit; a rising edge starts a sequence, clearing it ends the wait |
| up_scope | input | 1 | 1 = upstream-initiated (all downstream ports), 0 = single downstream port |
| port_sel | input | PORT_W | Downstream port index used in single-port scope |
| link_up | input | NUM_DS | Per-port link-up status |
| tlp_valid | input | 1 | TLP descriptor valid |
| tlp_port | input | PORT_W | Downstream port whose bridge the TLP is routed through |
| tlp_to_sec | input | 1 | TLP is routed to the secondary side of that bridge |
| tlp_cfg_self | input | 1 | TLP is a Type 0 configuration access to the port itself |
| busy | output | 1 | Sequence in progress |
| hot_reset_req | output | NUM_DS | Per-port request to send hot-reset training sets |
| flush_strobe | output | NUM_DS | Per-port one-cycle discard strobe for queued received TLPs |
| reg_reset_pulse | output | NUM_DS | Per-port one-cycle clear of non-sticky register fields |
| ur_valid | output | 1 | Verdict valid, one cycle after `tlp_valid` |
| ur_flag | output | 1 | TLP is to be answered as an unsupported request |

## Verification
The bench drops a port's link in the middle of the hot-reset phase. A design that re-derived the request from the live link, or that cleared the whole mask, would then assert the wrong ports or stop too early. The bench also changes `up_scope` and `port_sel` while busy, which catches a design that reads the live inputs rather than the captured ones. In one case software clears the control bit before the wait state is reached. A design that needed to see a falling edge would hang there, and one that skipped the wait state would end a cycle early. TLPs with every combination of the routing flags are sent to in-scope and out-of-scope ports, both while busy and while idle. These show whether the configuration exemption wins over the secondary-side flag and whether the port match is applied in the right scope.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOT    = 3'd1,
    ST_FLUSH  = 3'd2,
    ST_REGRST = 3'd3,
    ST_WAIT   = 3'd4,
    ST_RESUME = 3'd5
  } sbr_state_e;
endpackage

// File: rtl/sbr_seq_fsm.sv
module sbr_seq_fsm
  import sbr_pkg::*;
#(
  parameter int NUM_DS     = 4,
  parameter int HOT_CYCLES = 4,
  localparam int PORT_W    = (NUM_DS > 1) ? $clog2(NUM_DS) : 1,
  localparam int CNT_W     = (HOT_CYCLES > 1) ? $clog2(HOT_CYCLES + 1) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbr_ctl,
  input  logic              up_scope,
  input  logic [PORT_W-1:0] port_sel,
  output logic              ev_start,
  output logic              ev_hot_cont,
  output logic              ev_hot_end,
  output logic              ev_flush_end,
  output logic [NUM_DS-1:0] scope_new,
  output logic [NUM_DS-1:0] cap_scope,
  output logic              cap_up,
  output logic              busy
);
  localparam logic [NUM_DS-1:0] ONE_BIT  = {{(NUM_DS-1){1'b0}}, 1'b1};
  localparam logic [NUM_DS-1:0] ALL_BITS = {NUM_DS{1'b1}};
  localparam logic [CNT_W-1:0]  HOT_LAST = CNT_W'(HOT_CYCLES - 1);

  sbr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             ctl_q;

  assign scope_new    = up_scope ? ALL_BITS : (ONE_BIT << port_sel);
  assign ev_start     = (state_q == ST_IDLE) && sbr_ctl && !ctl_q;
  assign ev_hot_end   = (state_q == ST_HOT) && (cnt_q == HOT_LAST);
  assign ev_hot_cont  = (state_q == ST_HOT) && (cnt_q != HOT_LAST);
  assign ev_flush_end = (state_q == ST_FLUSH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (ev_start) state_d = ST_HOT;
      ST_HOT:    if (ev_hot_end) state_d = ST_FLUSH;
      ST_FLUSH:  state_d = ST_REGRST;
      ST_REGRST: state_d = ST_WAIT;
      ST_WAIT:   if (!sbr_ctl) state_d = ST_RESUME;
      ST_RESUME: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ctl_q     <= 1'b0;
      cap_scope <= '0;
      cap_up    <= 1'b0;
      busy      <= 1'b0;
    end else begin
      state_q <= state_d;
      ctl_q   <= sbr_ctl;
      busy    <= (state_d != ST_IDLE);
      if (ev_start) begin
        cap_scope <= scope_new;
        cap_up    <= up_scope;
        cnt_q     <= '0;
      end else if (ev_hot_cont) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbr_port_ctl.sv
module sbr_port_ctl #(
  parameter int NUM_DS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_hot_cont,
  input  logic              ev_hot_end,
  input  logic              ev_flush_end,
  input  logic [NUM_DS-1:0] scope_new,
  input  logic [NUM_DS-1:0] cap_scope,
  input  logic              cap_up,
  input  logic [NUM_DS-1:0] link_up,
  output logic [NUM_DS-1:0] hot_reset_req,
  output logic [NUM_DS-1:0] flush_strobe,
  output logic [NUM_DS-1:0] reg_reset_pulse
);
  for (genvar i = 0; i < NUM_DS; i++) begin : g_port
    logic mask_q;
    logic mask_nxt;

    assign mask_nxt = mask_q & link_up[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q             <= 1'b0;
        hot_reset_req[i]   <= 1'b0;
        flush_strobe[i]    <= 1'b0;
        reg_reset_pulse[i] <= 1'b0;
      end else begin
        if (ev_start) begin
          mask_q           <= scope_new[i] & link_up[i];
          hot_reset_req[i] <= scope_new[i] & link_up[i];
        end else if (ev_hot_cont) begin
          mask_q           <= mask_nxt;
          hot_reset_req[i] <= mask_nxt;
        end else begin
          mask_q           <= 1'b0;
          hot_reset_req[i] <= 1'b0;
        end
        flush_strobe[i]    <= ev_hot_end & cap_scope[i];
        reg_reset_pulse[i] <= ev_flush_end & cap_up;
      end
    end
  end
endmodule

// File: rtl/sbr_ur_filter.sv
module sbr_ur_filter #(
  parameter int NUM_DS  = 4,
  localparam int PORT_W = (NUM_DS > 1) ? $clog2(NUM_DS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [NUM_DS-1:0] cap_scope,
  input  logic              tlp_valid,
  input  logic [PORT_W-1:0] tlp_port,
  input  logic              tlp_to_sec,
  input  logic              tlp_cfg_self,
  output logic              ur_valid,
  output logic              ur_flag
);
  logic in_scope;
  logic reject;

  assign in_scope = (32'(tlp_port) < NUM_DS) && cap_scope[tlp_port];
  assign reject   = tlp_valid && busy && tlp_to_sec && !tlp_cfg_self && in_scope;

  always_ff @(posedge clk) begin
    if (rst) begin
      ur_valid <= 1'b0;
      ur_flag  <= 1'b0;
    end else begin
      ur_valid <= tlp_valid;
      ur_flag  <= reject;
    end
  end
endmodule

// File: rtl/sbr_reset_seq.sv
module sbr_reset_seq #(
  parameter int NUM_DS     = 4,
  parameter int HOT_CYCLES = 4,
  localparam int PORT_W    = (NUM_DS > 1) ? $clog2(NUM_DS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbr_ctl,
  input  logic              up_scope,
  input  logic [PORT_W-1:0] port_sel,
  input  logic [NUM_DS-1:0] link_up,
  input  logic              tlp_valid,
  input  logic [PORT_W-1:0] tlp_port,
  input  logic              tlp_to_sec,
  input  logic              tlp_cfg_self,
  output logic              busy,
  output logic [NUM_DS-1:0] hot_reset_req,
  output logic [NUM_DS-1:0] flush_strobe,
  output logic [NUM_DS-1:0] reg_reset_pulse,
  output logic              ur_valid,
  output logic              ur_flag
);
  logic              ev_start, ev_hot_cont, ev_hot_end, ev_flush_end;
  logic [NUM_DS-1:0] scope_new, cap_scope;
  logic              cap_up;

  sbr_seq_fsm #(.NUM_DS(NUM_DS), .HOT_CYCLES(HOT_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .sbr_ctl(sbr_ctl), .up_scope(up_scope), .port_sel(port_sel),
    .ev_start(ev_start), .ev_hot_cont(ev_hot_cont), .ev_hot_end(ev_hot_end),
    .ev_flush_end(ev_flush_end), .scope_new(scope_new), .cap_scope(cap_scope),
    .cap_up(cap_up), .busy(busy)
  );

  sbr_port_ctl #(.NUM_DS(NUM_DS)) u_ports (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_hot_cont(ev_hot_cont),
    .ev_hot_end(ev_hot_end), .ev_flush_end(ev_flush_end), .scope_new(scope_new),
    .cap_scope(cap_scope), .cap_up(cap_up), .link_up(link_up),
    .hot_reset_req(hot_reset_req), .flush_strobe(flush_strobe),
    .reg_reset_pulse(reg_reset_pulse)
  );

  sbr_ur_filter #(.NUM_DS(NUM_DS)) u_ur (
    .clk(clk), .rst(rst), .busy(busy), .cap_scope(cap_scope), .tlp_valid(tlp_valid),
    .tlp_port(tlp_port), .tlp_to_sec(tlp_to_sec), .tlp_cfg_self(tlp_cfg_self),
    .ur_valid(ur_valid), .ur_flag(ur_flag)
  );
endmodule

// File: rtl/sbr_reset_seq_chk.sv
module sbr_reset_seq_chk #(
  parameter int NUM_DS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [NUM_DS-1:0] link_up,
  input logic              tlp_valid,
  input logic              tlp_cfg_self,
  input logic [NUM_DS-1:0] hot_reset_req,
  input logic [NUM_DS-1:0] flush_strobe,
  input logic [NUM_DS-1:0] reg_reset_pulse,
  input logic              ur_valid,
  input logic              ur_flag
);
  // R2 / R3: a request is never held for a port whose link was sampled down
  a_r3_req_needs_link: assert property (@(posedge clk) disable iff (rst)
    (|hot_reset_req) |-> ((hot_reset_req & ~$past(link_up)) == '0));

  // R4: the flush strobe lasts a single cycle
  a_r4_flush_single: assert property (@(posedge clk) disable iff (rst)
    (|flush_strobe) |=> (flush_strobe == '0));

  // R5 / R6: the register clear is all ports or none
  a_r5_regrst_all: assert property (@(posedge clk) disable iff (rst)
    (|reg_reset_pulse) |-> (&reg_reset_pulse));

  // R1: sequence outputs appear only while busy
  a_r1_outputs_busy: assert property (@(posedge clk) disable iff (rst)
    (|{hot_reset_req, flush_strobe, reg_reset_pulse}) |-> busy);

  // R9: verdict valid follows the descriptor by one cycle
  a_r9_valid_delay: assert property (@(posedge clk) disable iff (rst)
    ur_valid == $past(tlp_valid));

  // R10: self config accesses and idle traffic are never rejected
  a_r10_no_ur_cfg: assert property (@(posedge clk) disable iff (rst)
    ur_flag |-> (!$past(tlp_cfg_self) && $past(busy)));

  // R2 / R4 / R5: the phases never overlap
  a_r2_phase_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|hot_reset_req, |flush_strobe, |reg_reset_pulse}));
endmodule

bind sbr_reset_seq sbr_reset_seq_chk #(.NUM_DS(NUM_DS)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .link_up(link_up), .tlp_valid(tlp_valid),
  .tlp_cfg_self(tlp_cfg_self), .hot_reset_req(hot_reset_req),
  .flush_strobe(flush_strobe), .reg_reset_pulse(reg_reset_pulse),
  .ur_valid(ur_valid), .ur_flag(ur_flag)
);

// File: tb/tb_sbr_reset_seq.sv
module tb_sbr_reset_seq;
  localparam int NUM_DS = 4;
  localparam int HOT_CYCLES = 4;
  localparam int PORT_W = 2;
  localparam int M_IDLE = 0, M_HOT = 1, M_FLUSH = 2, M_REG = 3, M_WAIT = 4, M_RES = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sbr_ctl = 1'b0, up_scope = 1'b0;
  logic [PORT_W-1:0] port_sel = '0, tlp_port = '0;
  logic [NUM_DS-1:0] link_up = '1;
  logic tlp_valid = 1'b0, tlp_to_sec = 1'b0, tlp_cfg_self = 1'b0;
  logic busy, ur_valid, ur_flag;
  logic [NUM_DS-1:0] hot_reset_req, flush_strobe, reg_reset_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_state = M_IDLE, m_cnt = 0;
  bit m_ctl_prev = 0, m_up = 0;
  logic [NUM_DS-1:0] m_scope = '0, m_mask = '0;
  logic [NUM_DS-1:0] e_hot = '0, e_flush = '0, e_reg = '0;
  bit e_busy = 0, e_urv = 0, e_ur = 0;

  always #4 clk = ~clk;

  sbr_reset_seq #(.NUM_DS(NUM_DS), .HOT_CYCLES(HOT_CYCLES)) dut (
    .clk(clk), .rst(rst), .sbr_ctl(sbr_ctl), .up_scope(up_scope), .port_sel(port_sel),
    .link_up(link_up), .tlp_valid(tlp_valid), .tlp_port(tlp_port), .tlp_to_sec(tlp_to_sec),
    .tlp_cfg_self(tlp_cfg_self), .busy(busy), .hot_reset_req(hot_reset_req),
    .flush_strobe(flush_strobe), .reg_reset_pulse(reg_reset_pulse),
    .ur_valid(ur_valid), .ur_flag(ur_flag)
  );

  task automatic model_step();
    int old_state = m_state;
    logic [NUM_DS-1:0] old_scope = m_scope;
    if (rst) begin
      m_state = M_IDLE; m_cnt = 0; m_ctl_prev = 0; m_up = 0; m_scope = '0; m_mask = '0;
      e_hot = '0; e_flush = '0; e_reg = '0; e_busy = 0; e_urv = 0; e_ur = 0;
      return;
    end
    e_hot = '0; e_flush = '0; e_reg = '0;
    case (old_state)
      M_IDLE: if (sbr_ctl && !m_ctl_prev) begin
        m_up = up_scope;
        m_scope = up_scope ? '1 : (NUM_DS'(1) << port_sel);
        m_mask = m_scope & link_up;
        m_cnt = 0; e_hot = m_mask; m_state = M_HOT;
      end
      M_HOT: begin
        m_mask = m_mask & link_up;
        if (m_cnt == HOT_CYCLES - 1) begin m_state = M_FLUSH; e_flush = m_scope; end
        else begin m_cnt++; e_hot = m_mask; end
      end
      M_FLUSH: begin m_state = M_REG; e_reg = m_up ? '1 : '0; end
      M_REG: m_state = M_WAIT;
      M_WAIT: if (!sbr_ctl) m_state = M_RES;
      default: m_state = M_IDLE;
    endcase
    e_urv = tlp_valid;
    e_ur = tlp_valid && old_state != M_IDLE && tlp_to_sec && !tlp_cfg_self && old_scope[tlp_port];
    e_busy = (m_state != M_IDLE);
    m_ctl_prev = sbr_ctl;
  endtask

  task automatic chk1(string tag, logic [NUM_DS-1:0] act, logic [NUM_DS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    chk1("R1 busy", NUM_DS'(busy), NUM_DS'(e_busy));
    chk1("R2/R3/R6 hot_reset_req", hot_reset_req, e_hot);
    chk1("R4/R6 flush_strobe", flush_strobe, e_flush);
    chk1("R5/R6 reg_reset_pulse", reg_reset_pulse, e_reg);
    chk1("R9 ur_valid", NUM_DS'(ur_valid), NUM_DS'(e_urv));
    chk1("R9/R10 ur_flag", NUM_DS'(ur_flag), NUM_DS'(e_ur));
    @(negedge clk);
  endtask

  // drive a varied TLP pattern from a seed
  task automatic tlp_drive(int s);
    tlp_valid    = (s % 5) != 4;
    tlp_port     = PORT_W'(s);
    tlp_to_sec   = ((s / 4) % 2) == 0;
    tlp_cfg_self = ((s / 8) % 3) == 1;
  endtask

  task automatic run_seq(bit up, int sel, logic [NUM_DS-1:0] links, int hold, int seed);
    up_scope = up; port_sel = PORT_W'(sel); link_up = links; sbr_ctl = 1'b1;
    for (int i = 0; i < hold; i++) begin
      tlp_drive(seed + i);
      tick();
    end
    sbr_ctl = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tlp_drive(seed + hold + i);
      tick();
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1: reset state and idle traffic (R10: no verdict while idle)
    for (int i = 0; i < 6; i++) begin tlp_drive(i); tick(); end
    // R2/R4/R6: single-port scope on port 2, all links up
    run_seq(1'b0, 2, 4'b1111, 12, 3);
    // R2/R5: upstream scope, ports 1 and 3 down at start
    run_seq(1'b1, 0, 4'b0101, 12, 17);
    // R3: link of port 1 drops mid hot-reset and returns
    up_scope = 1'b1; link_up = 4'b1111; sbr_ctl = 1'b1;
    tick(); tick();
    link_up = 4'b1101; tick();
    link_up = 4'b1111;
    for (int i = 0; i < 8; i++) begin tlp_drive(40 + i); tick(); end
    sbr_ctl = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    // R8: scope and select change while busy
    up_scope = 1'b0; port_sel = 2'd1; sbr_ctl = 1'b1; link_up = 4'b1111;
    tick();
    up_scope = 1'b1; port_sel = 2'd3;
    for (int i = 0; i < 12; i++) begin tlp_drive(60 + i); tick(); end
    sbr_ctl = 1'b0;
    for (int i = 0; i < 4; i++) begin tlp_drive(80 + i); tick(); end
    // R7: control bit cleared before the wait state is reached
    up_scope = 1'b0; port_sel = 2'd0; sbr_ctl = 1'b1;
    tick(); tick();
    sbr_ctl = 1'b0;
    for (int i = 0; i < 10; i++) begin tlp_drive(90 + i); tick(); end
    // R10: exhaustive flag combinations while busy on port 3
    up_scope = 1'b0; port_sel = 2'd3; sbr_ctl = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tlp_valid = 1'b1; tlp_port = PORT_W'(i); tlp_to_sec = i[2]; tlp_cfg_self = i[3];
      tick();
    end
    sbr_ctl = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule